// File: doc/BRIEF.md
# Bus Access Completion Watchdog

This block bounds how long a CPU access to display memory may stay pending on a slow host bus that times out. The memory arbiter normally favours display refresh traffic, so a CPU cycle can wait a long time. Software programs a 6-bit limit `n`. While a CPU memory access is outstanding, the block counts bus-clock pulses. When `8n + 7` pulses have been counted, it raises an urgent request. The external arbiter must then serve that access next, which bounds the rest of the wait to a fixed number of memory-clock cycles.

A timeout does not abort the access and does not flag an error. It only raises the access's arbitration priority. The bus clock is modelled as a one-cycle enable pulse (`bus_tick`) inside a single clock domain. A halving select makes only every second bus pulse count, which doubles the window. Accesses to control registers and to the block-transfer engine are not watched. A very small `n` takes bandwidth away from display refresh.

Top module: `bus_access_watchdog`

## Requirements
- R1: After a synchronous active-high reset, `urgent` is 0 and `lim_rdata` reads 0.
- R2: A write (`lim_we` high for one cycle) stores `lim_wdata[5:0]`, and `lim_rdata` shows the new value from the next cycle on.
- R3: With an armed limit of 0, `urgent` never asserts, whatever the bus pulses and the halving select are.
- R4: With halving off and an armed limit n>0, `urgent` rises in the cycle after the clock edge that samples the (8n+7)-th `bus_tick` pulse. Pulses are counted from the cycle after the access start. A pulse in the start cycle does not count.
- R5: With `halve_sel`=1 captured at access start, only every second `bus_tick` counts, the second pulse being the first one counted. `urgent` therefore rises after the 2·(8n+7)-th raw pulse.
- R6: Once asserted, `urgent` stays high until `acc_done` is seen, and it is low in the cycle after that.
- R7: If `acc_done` arrives before expiry, `urgent` never asserts for that access, and the next access counts its full window again from zero.
- R8: A start with `acc_target` = 1 (register access) or 2 (block-transfer access) arms nothing and never leads to `urgent`. Only `acc_target` = 0 (display memory) is watched.
- R9: The limit and the halving select are captured at access start. A limit write during an outstanding access takes effect from the next access.
- R10: A new `acc_start` while an access is outstanding is ignored. Only one access is tracked at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lim_we | input | 1 | Limit register write strobe |
| lim_wdata | input | 6 | Limit write value |
| lim_rdata | output | 6 | Limit register readback |
| acc_start | input | 1 | One-cycle strobe: a CPU access begins |
| acc_target | input | 2 | Target of the starting access: 0 memory, 1 register, 2 block transfer |
| acc_done | input | 1 | Completion of the outstanding access |
| bus_tick | input | 1 | Bus clock enable pulse |
| halve_sel | input | 1 | Count only every second bus pulse |
| urgent | output | 1 | Registered urgent request to the memory arbiter |

## Verification
A wrong count or a wrong terminal decode shows up on `urgent` as an assertion that comes one or more cycles early or late. The bench compares `urgent` in every cycle against the expected value, so such an error is caught in the first cycle where it differs. A wrong halving phase doubles the window or cuts it short, and the first expiry exposes it. A limit that is captured at the wrong time shows up on the access that follows a mid-access write. A stuck `busy` state shows up either as an `urgent` that never clears after `acc_done` or as a missing expiry on the next access.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  typedef enum logic [1:0] {
    TGT_MEM  = 2'd0,
    TGT_REG  = 2'd1,
    TGT_BLIT = 2'd2
  } wdg_target_e;

  function automatic logic is_watched(input logic [1:0] tgt);
    return tgt == TGT_MEM;
  endfunction
endpackage

// File: rtl/wdg_limit_reg.sv
module wdg_limit_reg #(
  parameter int LIMIT_W = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [LIMIT_W-1:0] wdata,
  output logic [LIMIT_W-1:0] value
);
  always_ff @(posedge clk) begin
    if (rst)     value <= '0;
    else if (we) value <= wdata;
  end
endmodule

// File: rtl/wdg_tick_gate.sv
module wdg_tick_gate (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  input  logic halve,
  input  logic bus_tick,
  output logic eff_tick
);
  logic phase;

  always_ff @(posedge clk) begin
    if (rst || clear)                  phase <= 1'b0;
    else if (run && bus_tick && halve) phase <= ~phase;
  end

  assign eff_tick = run && bus_tick && (!halve || phase);
endmodule

// File: rtl/wdg_window_cnt.sv
module wdg_window_cnt #(
  parameter int LIMIT_W = 6,
  localparam int CNT_W  = LIMIT_W + 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic               inc_en,
  input  logic [LIMIT_W-1:0] limit,
  output logic               expire
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] term;
  logic             step;

  assign term   = {limit, 3'b111};
  assign step   = inc_en && (limit != '0) && (cnt != term);
  assign expire = step && ((cnt + 1'b1) == term);

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (step)    cnt <= cnt + 1'b1;
  end

  p_count_bounded_r4: assert property (@(posedge clk) disable iff (rst)
    cnt <= term);
  p_zero_no_count_r3: assert property (@(posedge clk) disable iff (rst)
    (limit == '0) |-> !expire);
endmodule

// File: rtl/bus_access_watchdog.sv
module bus_access_watchdog #(
  parameter int LIMIT_W = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               lim_we,
  input  logic [LIMIT_W-1:0] lim_wdata,
  output logic [LIMIT_W-1:0] lim_rdata,
  input  logic               acc_start,
  input  logic [1:0]         acc_target,
  input  logic               acc_done,
  input  logic               bus_tick,
  input  logic               halve_sel,
  output logic               urgent
);
  import wdg_pkg::*;

  logic               busy;
  logic [LIMIT_W-1:0] n_cur;
  logic               halve_cur;
  logic               start_ok;
  logic               finish;
  logic               eff_tick;
  logic               expire;

  assign start_ok = acc_start && !busy && is_watched(acc_target);
  assign finish   = busy && acc_done;

  wdg_limit_reg #(.LIMIT_W(LIMIT_W)) u_reg (
    .clk(clk), .rst(rst), .we(lim_we), .wdata(lim_wdata), .value(lim_rdata)
  );

  wdg_tick_gate u_gate (
    .clk(clk), .rst(rst), .clear(start_ok), .run(busy && !acc_done),
    .halve(halve_cur), .bus_tick(bus_tick), .eff_tick(eff_tick)
  );

  wdg_window_cnt #(.LIMIT_W(LIMIT_W)) u_cnt (
    .clk(clk), .rst(rst), .clear(start_ok || finish), .inc_en(eff_tick),
    .limit(n_cur), .expire(expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      n_cur     <= '0;
      halve_cur <= 1'b0;
      urgent    <= 1'b0;
    end else begin
      if (start_ok) begin
        busy      <= 1'b1;
        n_cur     <= lim_rdata;
        halve_cur <= halve_sel;
      end else if (finish) begin
        busy      <= 1'b0;
      end
      if (finish)      urgent <= 1'b0;
      else if (expire) urgent <= 1'b1;
    end
  end

  p_urgent_only_busy_r6: assert property (@(posedge clk) disable iff (rst)
    urgent |-> busy);
  p_zero_silent_r3: assert property (@(posedge clk) disable iff (rst)
    (busy && n_cur == '0) |-> !urgent);
  p_urgent_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (urgent && !acc_done) |=> urgent);
  p_done_clears_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && acc_done) |=> (!urgent && !busy));
  p_foreign_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    (!busy && acc_start && !is_watched(acc_target)) |=> !busy);
  p_armed_stable_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && !acc_done) |=> $stable(n_cur) && $stable(halve_cur));
endmodule

// File: tb/tb_bus_access_watchdog.sv
`timescale 1ns/1ps
module tb_bus_access_watchdog;
  logic       clk = 1'b0;
  logic       rst;
  logic       lim_we;
  logic [5:0] lim_wdata;
  logic [5:0] lim_rdata;
  logic       acc_start;
  logic [1:0] acc_target;
  logic       acc_done;
  logic       bus_tick;
  logic       halve_sel;
  logic       urgent;

  int checks = 0;
  int errors = 0;
  bit    q_exp[$];
  string q_req[$];
  bit    m_e;
  string m_r;

  always #2.5 clk = ~clk;

  bus_access_watchdog dut (
    .clk(clk), .rst(rst), .lim_we(lim_we), .lim_wdata(lim_wdata),
    .lim_rdata(lim_rdata), .acc_start(acc_start), .acc_target(acc_target),
    .acc_done(acc_done), .bus_tick(bus_tick), .halve_sel(halve_sel),
    .urgent(urgent)
  );

  // monitor: compares urgent after each edge with the expected item queued by the driver
  always @(posedge clk) begin
    #1;
    if (q_exp.size() > 0) begin
      m_e = q_exp.pop_front();
      m_r = q_req.pop_front();
      checks++;
      if (urgent !== m_e) begin
        errors++;
        $display("FAIL %s: urgent actual %0b expected %0b at %0t", m_r, urgent, m_e, $time);
      end
    end
  end

  task automatic push(input bit e, input string r);
    q_exp.push_back(e);
    q_req.push_back(r);
  endtask

  task automatic check6(input logic [5:0] act, input logic [5:0] exp, input string r);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: lim_rdata actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic write_limit(input int v);
    lim_we = 1'b1; lim_wdata = 6'(v); push(1'b0, "R2");
    @(negedge clk);
    lim_we = 1'b0;
    check6(lim_rdata, 6'(v), "R2");
  endtask

  // n_lim: limit expected armed; tgt: target code; mid_wr: value written at cycle 2 (-1 none)
  task automatic access(input int n_lim, input bit h, input int gap, input int len,
                        input int tgt, input int mid_wr, input int restart_at,
                        input string r);
    int raw;
    int need;
    bit e;
    raw  = 0;
    need = (h ? 2 : 1) * (8 * n_lim + 7);
    halve_sel = h; acc_start = 1'b1; acc_target = 2'(tgt); bus_tick = 1'b0;
    push(1'b0, r);
    @(negedge clk);
    acc_start = 1'b0;
    for (int c = 1; c <= len; c++) begin
      bus_tick  = ((c % gap) == 0);
      raw      += (bus_tick ? 1 : 0);
      acc_done  = (c == len);
      lim_we    = (mid_wr >= 0) && (c == 2);
      lim_wdata = 6'(mid_wr < 0 ? 0 : mid_wr);
      acc_start = (c == restart_at);
      acc_target = 2'd0;
      halve_sel = ~h;
      e = (tgt == 0) && (n_lim != 0) && (raw >= need) && !acc_done;
      push(e, r);
      @(negedge clk);
    end
    bus_tick = 1'b0; acc_done = 1'b0; lim_we = 1'b0; acc_start = 1'b0;
    push(1'b0, r);
    @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; lim_we = 1'b0; lim_wdata = '0; acc_start = 1'b0; acc_target = '0;
    acc_done = 1'b0; bus_tick = 1'b0; halve_sel = 1'b0;
    repeat (3) @(negedge clk);
    checks++;
    if (urgent !== 1'b0) begin errors++; $display("FAIL R1: urgent actual %0b expected 0", urgent); end
    check6(lim_rdata, 6'd0, "R1");
    rst = 1'b0;
    @(negedge clk);

    // R4: exact expiry pulse, halving off
    write_limit(1);  access(1, 0, 1, 15 + 5, 0, -1, 0, "R4");
    write_limit(5);  access(5, 0, 1, 47 + 3, 0, -1, 0, "R4");
    access(5, 0, 3, 3 * 47 + 4, 0, -1, 0, "R4");
    write_limit(63); access(63, 0, 1, 511 + 2, 0, -1, 0, "R4");
    // R5: halving on
    write_limit(2);  access(2, 1, 1, 2 * 23 + 4, 0, -1, 0, "R5");
    access(2, 1, 2, 2 * 2 * 23 + 3, 0, -1, 0, "R5");
    write_limit(1);  access(1, 1, 1, 30 + 1, 0, -1, 0, "R5");
    // R3: zero limit never urgent
    write_limit(0);  access(0, 0, 1, 600, 0, -1, 0, "R3");
    access(0, 1, 1, 100, 0, -1, 0, "R3");
    // R7: early completion, then a full window
    write_limit(3);  access(3, 0, 1, 20, 0, -1, 0, "R7");
    access(3, 0, 1, 40, 0, -1, 0, "R7");
    // R8: register and block-transfer accesses are not watched
    access(3, 0, 1, 60, 1, -1, 0, "R8");
    access(3, 0, 1, 60, 2, -1, 0, "R8");
    // R9: mid-access write applies to the next access
    write_limit(4);  access(4, 0, 1, 50, 0, 1, 0, "R9");
    check6(lim_rdata, 6'd1, "R9");
    access(1, 0, 1, 20, 0, -1, 0, "R9");
    // R6: urgent held for many cycles until completion
    access(1, 0, 1, 15 + 30, 0, -1, 0, "R6");
    // R10: second start while outstanding does not restart the window
    access(1, 0, 1, 15 + 4, 0, -1, 10, "R10");

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++; errors++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule